// File: doc/BRIEF.md
# Mode-Banked Three-Read Two-Write Register File

This block is the architectural register store of a small processor core. Software names sixteen logical registers. The block holds thirty physical 32-bit registers, and a 3-bit mode input decides which physical copy each logical name reaches. Low registers and the top register are common to every mode. Some modes own private copies of some upper registers, so that a mode change needs no save or restore of those registers.

Three read ports are combinational. Two write ports commit on the rising clock edge. Each read port also checks the writes that are active in the current cycle. If a read and an active write resolve to the same physical register, the read returns the incoming data at once. Pipeline stages therefore see a value in the same cycle it is written. A synchronous active-high reset clears all storage.

Mode encoding: 0 = base, 1 = fast, 2/3/4 = privileged A/B/C, 5 = privileged D, 6 and 7 = treated as base.

Top module: `rf_banked_top`

## Requirements
- R1: Exactly 30 physical 32-bit registers exist. Across all modes, every distinct physical register can hold a different value at the same time.
- R2: Logical registers 0 to 7 and logical register 15 are one shared copy, whatever the mode. A value written in any mode is read back in every other mode.
- R3: In mode 1, logical registers 8 to 14 reach a private set of seven copies. These copies are separate from the base copies and from the copies of every other mode.
- R4: In modes 2, 3 and 4, each mode has its own private copies of logical registers 13 and 14. Logical registers 8 to 12 reach the base copies.
- R5: In mode 5, only logical register 14 has a private copy. Logical registers 8 to 13 reach the base copies.
- R6: Modes 0, 6 and 7 all reach the base copies of logical registers 8 to 14.
- R7: A write takes effect at the rising clock edge while its enable is high. The mode applied is the one present at that edge. With the enable low, the write has no effect.
- R8: The three read ports work independently. Each returns the register named by its own address in the same cycle.
- R9: If both write ports target the same physical register in one cycle, write port 0 is stored. If they target different registers, both values are stored.
- R10: A read whose physical target matches an active write in the same cycle returns that write's data. If both writes match, write port 0's data is returned.
- R11: A read whose target matches no active write returns the stored value. The value stays unchanged while no write touches it.
- R12: A synchronous reset clears all 30 registers to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Current mode; selects the banked copies |
| wr0_en | input | 1 | Write port 0 enable (higher priority) |
| wr0_addr | input | 4 | Write port 0 logical register |
| wr0_data | input | 32 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 4 | Write port 1 logical register |
| wr1_data | input | 32 | Write port 1 data |
| rd0_addr | input | 4 | Read port 0 logical register |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 4 | Read port 1 logical register |
| rd1_data | output | 32 | Read port 1 data |
| rd2_addr | input | 4 | Read port 2 logical register |
| rd2_data | output | 32 | Read port 2 data |

## Verification
A wrong bank mapping only shows up after a mode change. A value written in one mode either leaks into another mode or vanishes from a shared register, and this is seen on the first read of that logical name in the other mode. A wrong write priority or a wrong forwarding mux shows up on a read port in the same cycle as the colliding write, or one cycle later once the losing data has been stored. The bench follows every cycle with a model that tracks each bank owner separately. It switches modes often, so that a corrupted copy is exposed within a few cycles.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int LREGS   = 16;
  localparam int LA_W    = 4;
  localparam int MODE_W  = 3;
  localparam int NPHYS   = 30;
  localparam int PHYS_W  = $clog2(NPHYS);

  localparam int FAST_BASE = 16;  // fast copies of logical 8..14
  localparam int PRIV_BASE = 23;  // modes 2..4, two copies each
  localparam int PRVD_SLOT = 29;  // mode 5 copy of logical 14

  typedef enum logic [MODE_W-1:0] {
    MD_BASE = 3'd0,
    MD_FAST = 3'd1,
    MD_PRA  = 3'd2,
    MD_PRB  = 3'd3,
    MD_PRC  = 3'd4,
    MD_PRD  = 3'd5
  } md_e;

  function automatic logic [PHYS_W-1:0] map_phys(input logic [MODE_W-1:0] md,
                                                 input logic [LA_W-1:0] la);
    logic [PHYS_W-1:0] p;
    p = PHYS_W'(la);
    if (la >= 4'd8 && la <= 4'd14) begin
      case (md)
        MD_FAST: p = PHYS_W'(FAST_BASE + int'(la) - 8);
        MD_PRA, MD_PRB, MD_PRC:
          if (la >= 4'd13)
            p = PHYS_W'(PRIV_BASE + 2 * (int'(md) - 2) + int'(la) - 13);
        MD_PRD: if (la == 4'd14) p = PHYS_W'(PRVD_SLOT);
        default: p = PHYS_W'(la);
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [LA_W-1:0]   laddr,
  output logic [PHYS_W-1:0] paddr
);
  always_comb paddr = map_phys(mode, laddr);
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWR    = 2,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NWR-1:0]    we,
  input  logic [PHYS_W-1:0] wp [NWR],
  input  logic [DATA_W-1:0] wd [NWR],
  input  logic [PHYS_W-1:0] rp [NRD],
  output logic [DATA_W-1:0] rq [NRD]
);
  logic [DATA_W-1:0] mem [NPHYS];

  // Lower-numbered port is applied last, so it wins a collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else begin
      for (int w = NWR - 1; w >= 0; w--) begin
        if (we[w] && int'(wp[w]) < NPHYS) mem[wp[w]] <= wd[w];
      end
    end
  end

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rq[r] = (int'(rp[r]) < NPHYS) ? mem[rp[r]] : '0;
    end
  endgenerate

  // R9: a same-register collision keeps port 0 data
  a_r9_port0_wins: assert property (@(posedge clk) disable iff (rst)
    (we[0] && we[1] && wp[0] == wp[1]) |=> mem[$past(wp[0])] == $past(wd[0]));

  // R9: distinct targets both land
  a_r9_both_land: assert property (@(posedge clk) disable iff (rst)
    (we[0] && we[1] && wp[0] != wp[1]) |=> mem[$past(wp[1])] == $past(wd[1]));

  generate
    for (genvar i = 0; i < NPHYS; i++) begin : g_rst_chk
      // R12: reset clears every entry
      a_r12_reset_clear: assert property (@(posedge clk) rst |=> mem[i] == '0);
    end
  endgenerate
endmodule

// File: rtl/rf_fwd_mux.sv
module rf_fwd_mux
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWR    = 2
) (
  input  logic [PHYS_W-1:0] rphys,
  input  logic [DATA_W-1:0] stored,
  input  logic [NWR-1:0]    we,
  input  logic [PHYS_W-1:0] wp [NWR],
  input  logic [DATA_W-1:0] wd [NWR],
  output logic [DATA_W-1:0] rdata
);
  logic [NWR-1:0] hit;

  generate
    for (genvar w = 0; w < NWR; w++) begin : g_hit
      assign hit[w] = we[w] && (wp[w] == rphys);
    end
  endgenerate

  // Highest-numbered checked first so port 0 overrides.
  always_comb begin
    rdata = stored;
    for (int w = NWR - 1; w >= 0; w--) begin
      if (hit[w]) rdata = wd[w];
    end
  end
endmodule

// File: rtl/rf_banked_top.sv
module rf_banked_top
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic              wr0_en,
  input  logic [3:0]        wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [3:0]        wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic [3:0]        rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [3:0]        rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [3:0]        rd2_addr,
  output logic [DATA_W-1:0] rd2_data
);
  localparam int NWR = 2;
  localparam int NRD = 3;

  logic [NWR-1:0]    we;
  logic [LA_W-1:0]   wla   [NWR];
  logic [PHYS_W-1:0] wp    [NWR];
  logic [DATA_W-1:0] wd    [NWR];
  logic [LA_W-1:0]   rla   [NRD];
  logic [PHYS_W-1:0] rp    [NRD];
  logic [DATA_W-1:0] rq    [NRD];
  logic [DATA_W-1:0] rout  [NRD];

  assign we     = {wr1_en, wr0_en};
  assign wla[0] = wr0_addr;
  assign wla[1] = wr1_addr;
  assign wd[0]  = wr0_data;
  assign wd[1]  = wr1_data;
  assign rla[0] = rd0_addr;
  assign rla[1] = rd1_addr;
  assign rla[2] = rd2_addr;

  generate
    for (genvar w = 0; w < NWR; w++) begin : g_wmap
      rf_addr_map u_map (.mode(mode), .laddr(wla[w]), .paddr(wp[w]));
    end
    for (genvar r = 0; r < NRD; r++) begin : g_rport
      rf_addr_map u_map (.mode(mode), .laddr(rla[r]), .paddr(rp[r]));
      rf_fwd_mux #(.DATA_W(DATA_W), .NWR(NWR)) u_fwd (
        .rphys(rp[r]), .stored(rq[r]), .we(we), .wp(wp), .wd(wd),
        .rdata(rout[r]));
    end
  endgenerate

  rf_storage #(.DATA_W(DATA_W), .NWR(NWR), .NRD(NRD)) u_store (
    .clk(clk), .rst(rst), .we(we), .wp(wp), .wd(wd), .rp(rp), .rq(rq));

  assign rd0_data = rout[0];
  assign rd1_data = rout[1];
  assign rd2_data = rout[2];

  // R7: a write is visible on the next cycle at the same name and mode
  a_r7_commit_port0: assert property (@(posedge clk) disable iff (rst)
    ($past(wr0_en) && !$past(rst) && mode == $past(mode) &&
     rd0_addr == $past(wr0_addr) && !wr0_en && !wr1_en)
    |-> rd0_data == $past(wr0_data));

  // R10: same-cycle forwarding from port 0 to read port 1
  a_r10_bypass_port1: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && wr0_addr == rd1_addr) |-> rd1_data == wr0_data);

  // R11: without writes, a held address keeps its value
  a_r11_hold_port0: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr0_en && !wr1_en) && !wr0_en && !wr1_en &&
     $stable(rd0_addr) && $stable(mode)) |-> $stable(rd0_data));

  // R2: a shared name reads the same across a mode change
  a_r2_shared_port2: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr0_en && !wr1_en) && !wr0_en && !wr1_en && $stable(rd2_addr) &&
     (rd2_addr < 4'd8 || rd2_addr == 4'd15)) |-> $stable(rd2_data));
endmodule

// File: tb/rf_banked_top_test.sv
module rf_banked_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic        we0, we1;
  logic [3:0]  wa0, wa1;
  logic [31:0] wd0, wd1;
  logic [3:0]  ra [3];
  logic [31:0] rd [3];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] mdl [128];

  always #10 clk = ~clk;  // 50 MHz

  rf_banked_top uut (
    .clk(clk), .rst(rst), .mode(mode),
    .wr0_en(we0), .wr0_addr(wa0), .wr0_data(wd0),
    .wr1_en(we1), .wr1_addr(wa1), .wr1_data(wd1),
    .rd0_addr(ra[0]), .rd0_data(rd[0]),
    .rd1_addr(ra[1]), .rd1_data(rd[1]),
    .rd2_addr(ra[2]), .rd2_data(rd[2]));

  // Owner key: which mode's copy a name reaches (0 = base/shared).
  function automatic int owner_key(input int m, input int l);
    int own;
    own = 0;
    if (l >= 8 && l <= 14) begin
      if (m == 1) own = 1;
      else if (m >= 2 && m <= 4 && l >= 13) own = m;
      else if (m == 5 && l == 14) own = 5;
    end
    return own * 16 + l;
  endfunction

  function automatic logic [31:0] expect_rd(input int a);
    int k;
    k = owner_key(int'(mode), a);
    if (we0 && owner_key(int'(mode), int'(wa0)) == k) return wd0;
    if (we1 && owner_key(int'(mode), int'(wa1)) == k) return wd1;
    return mdl[k];
  endfunction

  task automatic idle();
    we0 = 0; we1 = 0; wa0 = 0; wa1 = 0; wd0 = 0; wd1 = 0;
  endtask

  // One cycle: inputs already driven after the falling edge.
  task automatic cyc(input string tag);
    #2;
    for (int p = 0; p < 3; p++) begin
      logic [31:0] e;
      e = expect_rd(int'(ra[p]));
      checks++;
      if (rd[p] !== e) begin
        fails++;
        $display("FAIL %s port%0d mode=%0d addr=%0d actual=%h expected=%h",
                 tag, p, mode, ra[p], rd[p], e);
      end
    end
    if (rst) begin
      for (int k = 0; k < 128; k++) mdl[k] = '0;
    end else begin
      if (we1) mdl[owner_key(int'(mode), int'(wa1))] = wd1;
      if (we0) mdl[owner_key(int'(mode), int'(wa0))] = wd0;
    end
    @(negedge clk);
  endtask

  task automatic wr(input int m, input int a, input logic [31:0] d, input string tag);
    idle(); mode = 3'(m); we0 = 1; wa0 = 4'(a); wd0 = d;
    ra[0] = 4'(a); ra[1] = 4'(a); ra[2] = 4'(a);
    cyc(tag);
  endtask

  task automatic rdall(input int m, input int a, input string tag);
    idle(); mode = 3'(m);
    ra[0] = 4'(a); ra[1] = 4'((a + 1) % 16); ra[2] = 4'((a + 15) % 16);
    cyc(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 128; k++) mdl[k] = 'x;
    rst = 1; mode = 0; idle();
    ra[0] = 0; ra[1] = 8; ra[2] = 15;
    @(negedge clk);
    for (int k = 0; k < 128; k++) mdl[k] = '0;
    @(negedge clk);
    rst = 0;
    // R12: every name in every mode reads zero after reset
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 16; a++) rdall(m, a, "R12");

    // R2: shared names written in one mode, read in all
    for (int a = 0; a < 8; a++) wr(a % 6, a, 32'h5A00_0000 + a, "R2");
    wr(3, 15, 32'hF00D_000F, "R2");
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 8; a++) rdall(m, a, "R2");
      rdall(m, 15, "R2");
    end

    // R1/R3/R4/R5/R6: fill every banked copy with distinct data
    for (int a = 8; a < 15; a++) wr(0, a, 32'hB000_0000 + a, "R6");
    for (int a = 8; a < 15; a++) wr(1, a, 32'hFA00_0000 + a, "R3");
    for (int m = 2; m < 5; m++) begin
      wr(m, 13, 32'hC000_0000 + m * 256 + 13, "R4");
      wr(m, 14, 32'hC000_0000 + m * 256 + 14, "R4");
    end
    wr(5, 14, 32'hD000_000E, "R5");
    for (int m = 0; m < 8; m++)
      for (int a = 8; a < 15; a++) rdall(m, a, "R1");
    // R6: write in alias modes 6 and 7 lands in base
    wr(6, 9, 32'h6666_0009, "R6");
    rdall(0, 9, "R6"); rdall(1, 9, "R6");
    wr(7, 14, 32'h7777_000E, "R6");
    rdall(0, 14, "R6"); rdall(5, 14, "R6"); rdall(2, 14, "R6");

    // R7: enable low has no effect, next cycle shows the commit
    idle(); mode = 1; wa0 = 10; wd0 = 32'hDEAD_BEEF; ra[0] = 10; ra[1] = 10; ra[2] = 10;
    cyc("R7");
    idle(); mode = 1; ra[0] = 10; cyc("R7");
    wr(4, 13, 32'h4444_1313, "R7");
    rdall(4, 13, "R7"); rdall(3, 13, "R7");

    // R9/R10: collisions on the same physical register
    idle(); mode = 2; we0 = 1; we1 = 1; wa0 = 14; wa1 = 14;
    wd0 = 32'h0000_AAAA; wd1 = 32'h0000_BBBB; ra[0] = 14; ra[1] = 14; ra[2] = 13;
    cyc("R10");
    rdall(2, 14, "R9");
    idle(); mode = 0; we0 = 1; we1 = 1; wa0 = 3; wa1 = 4;
    wd0 = 32'h3333_3333; wd1 = 32'h4444_4444; ra[0] = 3; ra[1] = 4; ra[2] = 5;
    cyc("R10");
    rdall(0, 3, "R9"); rdall(0, 4, "R9");
    idle(); mode = 1; we1 = 1; wa1 = 12; wd1 = 32'h1212_1212;
    ra[0] = 12; ra[1] = 11; ra[2] = 12;
    cyc("R10");
    rdall(0, 12, "R10");

    // R8: three ports on unrelated names
    idle(); mode = 1; ra[0] = 2; ra[1] = 8; ra[2] = 15; cyc("R8");
    idle(); mode = 3; ra[0] = 13; ra[1] = 14; ra[2] = 0; cyc("R8");

    // R11: hold without writes
    for (int i = 0; i < 4; i++) begin
      idle(); mode = 5; ra[0] = 14; ra[1] = 13; ra[2] = 7; cyc("R11");
    end

    // Mixed traffic with frequent mode changes
    for (int i = 0; i < 3000; i++) begin
      mode = 3'($urandom_range(0, 7));
      we0 = 1'($urandom); we1 = 1'($urandom);
      wa0 = 4'($urandom); wa1 = ($urandom_range(0, 3) == 0) ? wa0 : 4'($urandom);
      wd0 = $urandom; wd1 = $urandom;
      for (int p = 0; p < 3; p++)
        ra[p] = ($urandom_range(0, 2) == 0) ? wa0 : 4'($urandom);
      cyc("R10");
    end

    // R12: reset mid-run clears banked copies too
    idle(); rst = 1; mode = 1; ra[0] = 8; ra[1] = 0; ra[2] = 15; cyc("R12");
    rst = 0;
    for (int m = 0; m < 6; m++) rdall(m, 13, "R12");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule